// File: doc/BRIEF.md
# Serial Stereo PCM Receiver with Automatic Muting

This block takes stereo PCM audio from a three-wire style serial link and turns it into parallel samples in the system clock domain. A bit clock and a word clock are shared by two data lines, one per channel. Each line carries two's-complement samples with the most significant bit first. The bit clock, the word clock and both data lines are first brought into the system clock domain, and their edges are found there. A bit is taken from each data line on every rising edge of the bit clock. A falling edge of the word clock moves the newest word of each channel into the output registers and raises a one-cycle strobe. The bit clock may run in bursts or stop between words, because nothing depends on it running freely.

A select input sets the word length to 24 or 20 bits. A 20-bit word is placed in the upper bits of the 24-bit output with zeros below it, so the output is always a full-scale 24-bit two's-complement value. The block also drives a mute flag for the downstream modulator. The flag rises when the received sample pair stays the same for a set number of words, or when no word clock edge has arrived within a set window of system clocks. It falls on the first word that differs from the one before it.

Top module: `pcm_serial_rx`

## Requirements
- R1: During and right after reset, both sample outputs are zero and the strobe and the mute flag are low.
- R2: With the select input high, each word clock falling edge loads the last 24 bits taken from a data line before that edge into the matching sample output. The first bit taken is bit 23 of the output.
- R3: With the select input low, the last 20 bits taken before the edge go to output bits 23 down to 4, first bit in bit 23, and output bits 3 down to 0 are zero.
- R4: Data line levels count only at rising edges of the bit clock. Data changes while the bit clock is steady, bits taken earlier than the last word length, and uneven or paused bit clock timing have no effect on the loaded sample.
- R5: The strobe is high for exactly one system clock per word clock falling edge, in the cycle in which the new samples first appear. Rising word clock edges give no strobe, and the sample outputs change only together with the strobe.
- R6: The mute flag rises together with the strobe of the word that completes a run of CONST_WORDS consecutive identical left/right pairs. Before reset the previous pair counts as all zeros. It stays high while the pairs keep repeating.
- R7: The mute flag rises CLK_TIMEOUT+1 system clocks after the latest word clock falling edge was taken in (or after reset) if no further falling edge arrives in that time.
- R8: While muted, a word whose pair equals the previous pair leaves the flag high. The first word whose pair differs clears the flag, together with its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock, may be gated |
| wclk_i | input | 1 | Serial word clock; its falling edge loads samples |
| ldat_i | input | 1 | Left channel serial data |
| rdat_i | input | 1 | Right channel serial data |
| wide_i | input | 1 | Word length select: 1 = 24 bits, 0 = 20 bits |
| left_o | output | SAMPLE_W | Left sample, 24-bit two's complement |
| right_o | output | SAMPLE_W | Right sample, 24-bit two's complement |
| valid_o | output | 1 | One-cycle strobe marking new samples |
| mute_o | output | 1 | Automatic mute flag |

## Verification
A fault in a channel's shift register or in the placement of a 20-bit word shows up as a wrong sample, on the strobe that ends that word. Walking-one sweeps on both channels and both word lengths expose any bit that is misplaced or stuck. A run counter that is off by one moves the mute rise by one word, which is visible on a specific strobe. A watchdog that is wrong moves the time-out mute rise by a measurable number of cycles after the last word. A mute state that is not cleared shows when a differing word arrives and the flag stays high on that strobe.

// File: rtl/pcm_serial_rx_pkg.sv
package pcm_serial_rx_pkg;
   // number of audio channels carried on separate data lines
   localparam int unsigned NUM_CH = 2;

   // which transition of a synchronized line an edge finder reports
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_kind_e;
endpackage

// File: rtl/pcm_serial_rx_sync.sv
module pcm_serial_rx_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   // all lines share one flop chain so their relative timing is kept
   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d_i};
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pcm_serial_rx_edge.sv
module pcm_serial_rx_edge
   import pcm_serial_rx_pkg::*;
#(
   parameter edge_kind_e KIND = EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic pulse_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   generate
      if (KIND == EDGE_RISE) begin : g_rise
         assign pulse_o = lvl_i & ~prev_q;
      end else begin : g_fall
         assign pulse_o = ~lvl_i & prev_q;
      end
   endgenerate
endmodule

// File: rtl/pcm_serial_rx_deser.sv
module pcm_serial_rx_deser #(
   parameter int SAMPLE_W = 24,
   parameter int SHORT_W  = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                shift_i,
   input  logic                bit_i,
   input  logic                load_i,
   input  logic                wide_i,
   output logic [SAMPLE_W-1:0] next_o,
   output logic [SAMPLE_W-1:0] word_o
);
   localparam int PAD_W = SAMPLE_W - SHORT_W;

   logic [SAMPLE_W-1:0] sr_q;

   // free-running window: the newest SAMPLE_W bits, newest in bit 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sr_q <= '0;
      else if (shift_i) sr_q <= {sr_q[SAMPLE_W-2:0], bit_i};
   end

   // short words move to the top so the sign lands in the output MSB
   always_comb begin
      if (wide_i) next_o = sr_q;
      else        next_o = {sr_q[SHORT_W-1:0], {PAD_W{1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word_o <= '0;
      else if (load_i) word_o <= next_o;
   end
endmodule

// File: rtl/pcm_serial_rx_mute.sv
module pcm_serial_rx_mute #(
   parameter int SAMPLE_W    = 24,
   parameter int CONST_WORDS = 8192,
   parameter int CLK_TIMEOUT = 8192
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [SAMPLE_W-1:0] cur_l_i,
   input  logic [SAMPLE_W-1:0] cur_r_i,
   input  logic [SAMPLE_W-1:0] nxt_l_i,
   input  logic [SAMPLE_W-1:0] nxt_r_i,
   output logic                mute_o
);
   localparam int RUN_W = $clog2(CONST_WORDS + 1);
   localparam int TMR_W = $clog2(CLK_TIMEOUT + 1);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(CONST_WORDS);
   localparam logic [RUN_W-1:0] RUN_ARM = RUN_W'(CONST_WORDS - 1);
   localparam logic [TMR_W-1:0] TMR_MAX = TMR_W'(CLK_TIMEOUT);

   logic [RUN_W-1:0] run_q;
   logic [TMR_W-1:0] tmr_q;
   logic             same;
   logic             lost;

   // the output registers still hold the previous pair when a load arrives
   assign same = (cur_l_i == nxt_l_i) && (cur_r_i == nxt_r_i);
   assign lost = (tmr_q == TMR_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (load_i) begin
         if (!same)                run_q <= RUN_W'(1);
         else if (run_q != RUN_MAX) run_q <= run_q + RUN_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            tmr_q <= '0;
      else if (load_i)       tmr_q <= '0;
      else if (!lost)        tmr_q <= tmr_q + TMR_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mute_o <= 1'b0;
      end else if (load_i) begin
         if (!same)                mute_o <= 1'b0;
         else if (run_q >= RUN_ARM) mute_o <= 1'b1;
      end else if (lost) begin
         mute_o <= 1'b1;
      end
   end
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
   import pcm_serial_rx_pkg::*;
#(
   parameter int SAMPLE_W    = 24,
   parameter int SHORT_W     = 20,
   parameter int SYNC_STAGES = 2,
   parameter int CONST_WORDS = 8192,
   parameter int CLK_TIMEOUT = 8192
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bclk_i,
   input  logic                wclk_i,
   input  logic                ldat_i,
   input  logic                rdat_i,
   input  logic                wide_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o,
   output logic                mute_o
);
   localparam int LINES  = 2 + NUM_CH;
   localparam int L_BCLK = 0;
   localparam int L_WCLK = 1;
   localparam int L_DAT0 = 2;

   generate
      if (SHORT_W < 1 || SHORT_W >= SAMPLE_W) begin : g_bad_short
         $error("SHORT_W must lie between 1 and SAMPLE_W-1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CONST_WORDS < 2) begin : g_bad_run
         $error("CONST_WORDS must be at least 2");
      end
      if (CLK_TIMEOUT < 2) begin : g_bad_tmo
         $error("CLK_TIMEOUT must be at least 2");
      end
   endgenerate

   logic [LINES-1:0] raw;
   logic [LINES-1:0] syn;
   logic             bit_tick;
   logic             word_tick;
   logic             valid_q;
   logic [NUM_CH-1:0][SAMPLE_W-1:0] nxt_w;
   logic [NUM_CH-1:0][SAMPLE_W-1:0] cur_w;

   assign raw = {rdat_i, ldat_i, wclk_i, bclk_i};

   pcm_serial_rx_sync #(
      .WIDTH  (LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw),
      .q_o   (syn)
   );

   pcm_serial_rx_edge #(.KIND(EDGE_RISE)) u_bit_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (syn[L_BCLK]),
      .pulse_o (bit_tick)
   );

   pcm_serial_rx_edge #(.KIND(EDGE_FALL)) u_word_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (syn[L_WCLK]),
      .pulse_o (word_tick)
   );

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
         pcm_serial_rx_deser #(
            .SAMPLE_W (SAMPLE_W),
            .SHORT_W  (SHORT_W)
         ) u_deser (
            .clk     (clk),
            .rst_n   (rst_n),
            .shift_i (bit_tick),
            .bit_i   (syn[L_DAT0 + ch]),
            .load_i  (word_tick),
            .wide_i  (wide_i),
            .next_o  (nxt_w[ch]),
            .word_o  (cur_w[ch])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= word_tick;
   end

   pcm_serial_rx_mute #(
      .SAMPLE_W    (SAMPLE_W),
      .CONST_WORDS (CONST_WORDS),
      .CLK_TIMEOUT (CLK_TIMEOUT)
   ) u_mute (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (word_tick),
      .cur_l_i (cur_w[0]),
      .cur_r_i (cur_w[1]),
      .nxt_l_i (nxt_w[0]),
      .nxt_r_i (nxt_w[1]),
      .mute_o  (mute_o)
   );

   assign left_o  = cur_w[0];
   assign right_o = cur_w[1];
   assign valid_o = valid_q;
endmodule

// File: rtl/pcm_serial_rx_chk.sv
module pcm_serial_rx_chk #(
   parameter int SAMPLE_W    = 24,
   parameter int SHORT_W     = 20,
   parameter int CLK_TIMEOUT = 8192
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wide_i,
   input logic [SAMPLE_W-1:0] left_o,
   input logic [SAMPLE_W-1:0] right_o,
   input logic                valid_o,
   input logic                mute_o
);
   localparam int PAD_W = SAMPLE_W - SHORT_W;
   localparam int GAP_W = $clog2(CLK_TIMEOUT + 1);
   localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(CLK_TIMEOUT);
   localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(CLK_TIMEOUT - 1);

   // cycles since the strobe was last seen, counted independently
   logic [GAP_W-1:0] gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              gap_q <= '0;
      else if (valid_o)        gap_q <= '0;
      else if (gap_q != GAP_MAX) gap_q <= gap_q + GAP_W'(1);
   end

   a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   a_r5_data_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ((left_o != $past(left_o)) || (right_o != $past(right_o))) |-> valid_o);

   a_r3_short_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !$past(wide_i)) |->
         (left_o[PAD_W-1:0] == '0 && right_o[PAD_W-1:0] == '0));

   a_r6_mute_on_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mute_o) && valid_o) |->
         (left_o == $past(left_o) && right_o == $past(right_o)));

   a_r7_mute_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mute_o) && !valid_o) |-> (gap_q >= GAP_MIN));

   a_r8_clear_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mute_o) |->
         (valid_o && (left_o != $past(left_o) || right_o != $past(right_o))));
endmodule

bind pcm_serial_rx pcm_serial_rx_chk #(
   .SAMPLE_W    (SAMPLE_W),
   .SHORT_W     (SHORT_W),
   .CLK_TIMEOUT (CLK_TIMEOUT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wide_i  (wide_i),
   .left_o  (left_o),
   .right_o (right_o),
   .valid_o (valid_o),
   .mute_o  (mute_o)
);

// File: tb/pcm_serial_rx_test.sv
module pcm_serial_rx_test;
   localparam int SW  = 24;
   localparam int RUN = 4;
   localparam int TMO = 600;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk = 1'b0, wclk = 1'b0, ldat = 1'b0, rdat = 1'b0, wide = 1'b1;
   logic [SW-1:0] left, right;
   logic valid, mute;

   int total = 0, bad = 0, vcount = 0, frames = 0;
   logic [SW-1:0] m_l = '0, m_r = '0;
   int m_run = 0;
   logic m_mute = 1'b0;

   pcm_serial_rx #(
      .SAMPLE_W (SW), .SHORT_W (20), .SYNC_STAGES (2),
      .CONST_WORDS (RUN), .CLK_TIMEOUT (TMO)
   ) uut (
      .clk (clk), .rst_n (rst_n), .bclk_i (bclk), .wclk_i (wclk),
      .ldat_i (ldat), .rdat_i (rdat), .wide_i (wide),
      .left_o (left), .right_o (right), .valid_o (valid), .mute_o (mute)
   );

   always #4 clk = ~clk;

   always @(negedge clk) if (rst_n && valid) vcount++;

   task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // one word per channel: lead junk bits, then nbits MSB first, then word clock falls
   task automatic send(logic [SW-1:0] lv, logic [SW-1:0] rv, int nbits, int lead,
                       bit noisy, bit jitter, string dtag, string mtag);
      logic [SW-1:0] el, er;
      bit got, same;
      wide = (nbits == SW);
      wclk = 1'b1;
      for (int i = 0; i < lead + nbits; i++) begin
         int h;
         h = jitter ? 2 + (i % 5) : 3;
         if (i < lead) begin
            ldat = i[0]; rdat = ~i[0];
         end else begin
            ldat = lv[nbits-1-(i-lead)];
            rdat = rv[nbits-1-(i-lead)];
         end
         bclk = 1'b0; idle(h);
         bclk = 1'b1; idle(1);
         if (noisy) begin ldat = ~ldat; rdat = ~rdat; end
         idle(h - 1);
         if (jitter && i == 9) begin bclk = 1'b0; idle(25); end
      end
      bclk = 1'b0; idle(2);
      wclk = 1'b0;
      got = 1'b0;
      for (int t = 0; t < 10 && !got; t++) begin
         @(negedge clk);
         if (valid) got = 1'b1;
      end
      frames++;
      el = wide ? lv : {lv[19:0], 4'h0};
      er = wide ? rv : {rv[19:0], 4'h0};
      same = (el == m_l) && (er == m_r);
      if (same) m_run = (m_run < RUN) ? m_run + 1 : RUN;
      else      m_run = 1;
      if (!same)            m_mute = 1'b0;
      else if (m_run >= RUN) m_mute = 1'b1;
      m_l = el; m_r = er;
      check_eq({"R5 strobe seen ", dtag}, {31'd0, got}, 32'd1);
      check_eq({dtag, " left"}, {8'd0, left}, {8'd0, el});
      check_eq({dtag, " right"}, {8'd0, right}, {8'd0, er});
      check_eq({mtag, " mute"}, {31'd0, mute}, {31'd0, m_mute});
      idle(1);
      check_eq("R5 strobe one cycle", {31'd0, valid}, 32'd0);
      check_eq("R5 strobe count", vcount, frames);
   endtask

   initial begin
      idle(5);
      check_eq("R1 left in reset", {8'd0, left}, 32'd0);
      check_eq("R1 right in reset", {8'd0, right}, 32'd0);
      check_eq("R1 strobe in reset", {31'd0, valid}, 32'd0);
      rst_n = 1'b1;
      idle(2);
      check_eq("R1 mute after reset", {31'd0, mute}, 32'd0);
      check_eq("R1 strobe after reset", {31'd0, valid}, 32'd0);

      // R2: walking ones on both channels, 24-bit words
      for (int b = 0; b < SW; b++)
         send(24'h1 << b, ~(24'h1 << b), 24, 0, 1'b0, 1'b0, "R2", "R6");
      send(24'h800000, 24'h7FFFFF, 24, 0, 1'b0, 1'b0, "R2", "R6");
      send(24'hFFFFFF, 24'h000001, 24, 0, 1'b0, 1'b0, "R2", "R6");

      // R3: walking ones, 20-bit words placed at the top
      for (int b = 0; b < 20; b++)
         send(24'h1 << b, 24'hFFFFF ^ (24'h1 << b), 20, 0, 1'b0, 1'b0, "R3", "R6");
      send(24'h80000, 24'h7FFFF, 20, 0, 1'b0, 1'b0, "R3", "R6");

      // R4: junk lead bits, data glitches while clock steady, uneven bursts
      send(24'hA5C3E1, 24'h5A3C1E, 24, 8, 1'b1, 1'b0, "R4", "R6");
      send(24'h3C96F, 24'hC3690, 20, 6, 1'b1, 1'b0, "R4", "R6");
      send(24'h1B2D4E, 24'hE4D2B1, 24, 3, 1'b0, 1'b1, "R4", "R6");

      // R6: a run of identical pairs mutes on its RUN-th word
      for (int k = 0; k < RUN + 1; k++)
         send(24'h123456, 24'h654321, 24, 0, 1'b0, 1'b0, "R6", "R6");
      check_eq("R6 muted after run", {31'd0, mute}, 32'd1);
      send(24'h222222, 24'h654321, 24, 0, 1'b0, 1'b0, "R8", "R8");
      for (int k = 0; k < RUN; k++)
         send(24'h0, 24'h0, 24, 0, 1'b0, 1'b0, "R6", "R6");
      check_eq("R6 zero run muted", {31'd0, mute}, 32'd1);
      send(24'h000010, 24'h0, 24, 0, 1'b0, 1'b0, "R8", "R8");

      // R7: word clock stops; valid was seen one cycle ago
      idle(TMO - 3);
      check_eq("R7 mute before window", {31'd0, mute}, 32'd0);
      idle(4);
      check_eq("R7 mute after window", {31'd0, mute}, 32'd1);
      m_mute = 1'b1;

      // R8: repeated word keeps mute, changed word clears it
      send(24'h000010, 24'h0, 24, 0, 1'b0, 1'b0, "R8", "R8");
      check_eq("R8 repeat keeps mute", {31'd0, mute}, 32'd1);
      send(24'h7A7A7A, 24'h0, 24, 0, 1'b0, 1'b0, "R8", "R8");
      check_eq("R8 change clears mute", {31'd0, mute}, 32'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule